// File: doc/BRIEF.md
# Adaptive Block-Matching Search Controller

This controller runs the motion search for a single macroblock. It does no pixel arithmetic. It sends a center vector and a step size to an external candidate-evaluation datapath. That datapath returns the costs of nine candidates in parallel: the center and its eight neighbours at the given step. The controller masks the costs, picks the cheapest candidate and moves the center to it. After the last step it presents the motion vector together with a one-cycle done pulse.

Each search opens with a zero-displacement request. The cost returned for that point is compared with a threshold input, and the comparison sets the mode for the block:

- **Small-motion blocks** use unit steps around the moving center. The search stops as soon as the center wins, or after the step limit.
- **Large-motion blocks** use a step that starts at four and halves on every step (4, 2, 1), always for three steps.

The threshold, the vector limits and the step schedule are parameters or inputs, so the search can be retuned without changing its structure.

Top module: `adaptive_bm_ctrl`

## Requirements
- R1: The first request of every search has center (0,0) and step 0. The cost at result slot 0 of that request is the origin cost.
- R2: If the origin cost is strictly below `thresh`, the block is small-motion and `mode_large` is 0. Otherwise `mode_large` is 1. The decision is made anew for every search.
- R3: In small-motion mode every step request uses step 1. The search ends after the first step whose winner is the center (slot 0), or after three steps, whichever comes first.
- R4: In large-motion mode the step requests use steps 4, 2 and 1, in that order, and the search always ends after exactly three steps.
- R5: Result slot i holds the cost of center + offset(i) × step. The offsets are: 0:(0,0), 1:(-1,-1), 2:(0,-1), 3:(1,-1), 4:(-1,0), 5:(1,0), 6:(-1,1), 7:(0,1), 8:(1,1), written as (x,y). The winner becomes the next center and, after the last step, the motion vector.
- R6: Among candidates of equal cost, the lowest slot index wins.
- R7: A candidate with either component outside [MV_LO, MV_HI] (default -15..16) has its cost forced to all ones. The final vector always lies inside that range.
- R8: `done` is high for exactly one cycle, and in that cycle `busy` is low. `mv_x` and `mv_y` (signed, 6 bits) hold the result until the next search starts.
- R9: A `start` pulse that arrives while `busy` is high is ignored. The running search gives one done and the expected number of requests.
- R10: Only one request is outstanding at a time. `eval_req` is a one-cycle pulse, and the next one follows only after `res_valid`.
- R11: After reset `busy`, `done` and `eval_req` are low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin a search (ignored while busy) |
| thresh | input | CW | Mode threshold for the origin cost |
| busy | output | 1 | Search in progress |
| eval_req | output | 1 | Request pulse to the datapath |
| eval_cx | output | VW | Center x of the request |
| eval_cy | output | VW | Center y of the request |
| eval_step | output | 3 | Step size of the request (0 = origin only) |
| res_valid | input | 1 | Costs valid, one cycle |
| res_cost | input | 9*CW | Nine costs, slot i at bits [i*CW +: CW] |
| mode_large | output | 1 | Mode chosen for the current or last block |
| done | output | 1 | One-cycle completion pulse |
| mv_x | output | VW | Final motion vector x (signed) |
| mv_y | output | VW | Final motion vector y (signed) |

## Verification
Suppose the center register, step register or step counter goes wrong. Within one step, the symptom appears at the ports as a wrong `eval_cx`/`eval_cy`/`eval_step` on the next request. It can also appear as a wrong number of requests before `done`. The bench logs every request's step and the first request's center, and compares them with an independent model of the search. A wrong winner, a broken tie rule or a failed range mask can remain hidden until the vector is presented. The cost surfaces are therefore chosen with ties, steep slopes and targets near the range limit, and a second instance with a narrow vector range makes the mask decide the result.

// File: rtl/adaptive_bm_ctrl.sv
module adaptive_bm_ctrl #(
  parameter int CW         = 16,
  parameter int VW         = 6,
  parameter int MV_LO      = -15,
  parameter int MV_HI      = 16,
  parameter int LARGE_STEP = 4,
  parameter int NSTEP      = 3
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 start,
  input  logic [CW-1:0]        thresh,
  output logic                 busy,
  output logic                 eval_req,
  output logic signed [VW-1:0] eval_cx,
  output logic signed [VW-1:0] eval_cy,
  output logic [2:0]           eval_step,
  input  logic                 res_valid,
  input  logic [9*CW-1:0]      res_cost,
  output logic                 mode_large,
  output logic                 done,
  output logic signed [VW-1:0] mv_x,
  output logic signed [VW-1:0] mv_y
);
  localparam int NCAND = 9;
  localparam int EW    = VW + 2;
  localparam int CNTW  = $clog2(NSTEP + 1);
  localparam logic signed [EW-1:0] LO_V = EW'(MV_LO);
  localparam logic signed [EW-1:0] HI_V = EW'(MV_HI);

  typedef enum logic [2:0] {S_IDLE, S_ORG, S_WT0, S_ISS, S_WT} st_t;
  st_t state;

  logic signed [VW-1:0] cx, cy;
  logic [2:0]           step;
  logic [CNTW-1:0]      cnt;

  logic signed [EW-1:0] cxe, cye, ste;
  logic signed [EW-1:0] px [NCAND];
  logic signed [EW-1:0] py [NCAND];
  logic [CW-1:0]        mc [NCAND];
  logic [3:0]           win;
  logic [CW-1:0]        wcost;
  logic                 last;

  assign cxe = EW'(cx);
  assign cye = EW'(cy);
  assign ste = signed'({{(EW-3){1'b0}}, step});

  for (genvar g = 0; g < NCAND; g++) begin : cand
    localparam int J  = (g == 0) ? 4 : ((g <= 4) ? g - 1 : g);
    localparam int OX = J % 3 - 1;
    localparam int OY = J / 3 - 1;
    logic signed [EW-1:0] dx, dy;
    assign dx = (OX == 0) ? '0 : ((OX > 0) ? ste : -ste);
    assign dy = (OY == 0) ? '0 : ((OY > 0) ? ste : -ste);
    assign px[g] = cxe + dx;
    assign py[g] = cye + dy;
    assign mc[g] = (px[g] >= LO_V && px[g] <= HI_V && py[g] >= LO_V && py[g] <= HI_V)
                   ? res_cost[g*CW +: CW] : {CW{1'b1}};
  end

  always_comb begin
    win   = '0;
    wcost = mc[0];
    for (int i = 1; i < NCAND; i++) begin
      if (mc[i] < wcost) begin
        wcost = mc[i];
        win   = 4'(i);
      end
    end
  end

  assign last = (cnt == CNTW'(NSTEP - 1)) || (!mode_large && win == 4'd0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state      <= S_IDLE;
      cx         <= '0;
      cy         <= '0;
      step       <= '0;
      cnt        <= '0;
      mode_large <= 1'b0;
      done       <= 1'b0;
    end else begin
      done <= 1'b0;
      case (state)
        S_IDLE: if (start) begin
          state <= S_ORG;
          cx    <= '0;
          cy    <= '0;
          step  <= '0;
          cnt   <= '0;
        end
        S_ORG: state <= S_WT0;
        S_WT0: if (res_valid) begin
          mode_large <= !(res_cost[CW-1:0] < thresh);
          step       <= (res_cost[CW-1:0] < thresh) ? 3'd1 : 3'(LARGE_STEP);
          state      <= S_ISS;
        end
        S_ISS: state <= S_WT;
        S_WT: if (res_valid) begin
          cx  <= px[win][VW-1:0];
          cy  <= py[win][VW-1:0];
          cnt <= cnt + 1'b1;
          if (last) begin
            done  <= 1'b1;
            state <= S_IDLE;
          end else begin
            if (mode_large) step <= step >> 1;
            state <= S_ISS;
          end
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  assign busy      = (state != S_IDLE);
  assign eval_req  = (state == S_ORG) || (state == S_ISS);
  assign eval_cx   = cx;
  assign eval_cy   = cy;
  assign eval_step = step;
  assign mv_x      = cx;
  assign mv_y      = cy;
endmodule

module adaptive_bm_ctrl_chk #(
  parameter int VW         = 6,
  parameter int MV_LO      = -15,
  parameter int MV_HI      = 16,
  parameter int LARGE_STEP = 4
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 busy,
  input logic                 eval_req,
  input logic [2:0]           eval_step,
  input logic                 mode_large,
  input logic                 done,
  input logic signed [VW-1:0] mv_x,
  input logic signed [VW-1:0] mv_y
);
  // R8
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n) done |=> !done);
  // R8
  done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n) done |-> !busy);
  // R10
  req_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n) eval_req |=> !eval_req);
  // R3
  small_unit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (eval_req && eval_step != 3'd0 && !mode_large) |-> eval_step == 3'd1);
  // R4
  large_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (eval_req && mode_large) |-> ($countones(eval_step) <= 1 && int'(eval_step) <= LARGE_STEP));
  // R7
  mv_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (int'(mv_x) >= MV_LO && int'(mv_x) <= MV_HI && int'(mv_y) >= MV_LO && int'(mv_y) <= MV_HI));
endmodule

bind adaptive_bm_ctrl adaptive_bm_ctrl_chk #(
  .VW(VW), .MV_LO(MV_LO), .MV_HI(MV_HI), .LARGE_STEP(LARGE_STEP)
) u_chk (
  .clk(clk), .rst_n(rst_n), .busy(busy), .eval_req(eval_req), .eval_step(eval_step),
  .mode_large(mode_large), .done(done), .mv_x(mv_x), .mv_y(mv_y)
);

// File: tb/tb_adaptive_bm_ctrl.sv
module tb_cand_src #(parameter int CW = 16) (
  input  logic              clk,
  input  logic              clr,
  input  logic              eval_req,
  input  logic signed [5:0] cx,
  input  logic signed [5:0] cy,
  input  logic [2:0]        step,
  input  logic              done,
  input  int                tx, ty, base, wx, wy, k1, k2,
  output logic              res_valid,
  output logic [9*CW-1:0]   res_cost,
  output int                nreq,
  output int                ndone,
  output logic [23:0]       slog,
  output logic              first_bad
);
  int wt, lx, ly, ls;

  function automatic int costf(input int x, input int y);
    int ax, ay;
    ax = (x > tx) ? x - tx : tx - x;
    ay = (y > ty) ? y - ty : ty - y;
    return base + wx * ax + wy * ay + (((x + 40) * k1 + (y + 40) * k2) % 8);
  endfunction

  initial begin
    res_valid = 0; res_cost = '0; nreq = 0; ndone = 0; slog = '0; first_bad = 0; wt = 0;
  end

  always @(negedge clk) begin
    res_valid = 0;
    if (clr) begin
      nreq = 0; ndone = 0; slog = '0; first_bad = 0; wt = 0;
    end else begin
      if (done) ndone++;
      if (wt > 0) begin
        wt--;
        if (wt == 0) begin
          for (int i = 0; i < 9; i++) begin
            int j;
            j = (i == 0) ? 4 : ((i <= 4) ? i - 1 : i);
            res_cost[i*CW +: CW] = CW'(costf(lx + (j % 3 - 1) * ls, ly + (j / 3 - 1) * ls));
          end
          res_valid = 1;
        end
      end
      if (eval_req) begin
        if (nreq == 0 && (cx != 0 || cy != 0 || step != 0)) first_bad = 1;
        if (nreq < 8) slog[nreq*3 +: 3] = step;
        nreq++;
        lx = int'(cx); ly = int'(cy); ls = int'(step);
        wt = 1 + int'($urandom % 3);
      end
    end
  end
endmodule

module tb_adaptive_bm_ctrl;
  localparam int CLK_PERIOD = 10;
  localparam int CW = 16;
  localparam int NLO = -3;
  localparam int NHI = 2;

  logic clk = 0, rst_n = 0, start = 0, clr = 0;
  logic [CW-1:0] thresh = '0;
  int tx = 0, ty = 0, base = 100, wx = 1, wy = 1, k1 = 0, k2 = 0;
  int checks = 0, errors = 0, cyc = 0;

  logic busy_a, req_a, rv_a, mode_a, done_a;
  logic signed [5:0] cx_a, cy_a, mvx_a, mvy_a;
  logic [2:0] st_a;
  logic [9*CW-1:0] rc_a;
  int nreq_a, ndone_a;
  logic [23:0] slog_a;
  logic fb_a;

  logic busy_b, req_b, rv_b, mode_b, done_b;
  logic signed [5:0] cx_b, cy_b, mvx_b, mvy_b;
  logic [2:0] st_b;
  logic [9*CW-1:0] rc_b;
  int nreq_b, ndone_b;
  logic [23:0] slog_b;
  logic fb_b;

  always #(CLK_PERIOD/2) clk = ~clk;

  adaptive_bm_ctrl dut (
    .clk(clk), .rst_n(rst_n), .start(start), .thresh(thresh), .busy(busy_a),
    .eval_req(req_a), .eval_cx(cx_a), .eval_cy(cy_a), .eval_step(st_a),
    .res_valid(rv_a), .res_cost(rc_a), .mode_large(mode_a), .done(done_a),
    .mv_x(mvx_a), .mv_y(mvy_a));

  adaptive_bm_ctrl #(.MV_LO(NLO), .MV_HI(NHI)) dut_narrow (
    .clk(clk), .rst_n(rst_n), .start(start), .thresh(thresh), .busy(busy_b),
    .eval_req(req_b), .eval_cx(cx_b), .eval_cy(cy_b), .eval_step(st_b),
    .res_valid(rv_b), .res_cost(rc_b), .mode_large(mode_b), .done(done_b),
    .mv_x(mvx_b), .mv_y(mvy_b));

  tb_cand_src #(.CW(CW)) src_a (.clk(clk), .clr(clr), .eval_req(req_a), .cx(cx_a), .cy(cy_a),
    .step(st_a), .done(done_a), .tx(tx), .ty(ty), .base(base), .wx(wx), .wy(wy), .k1(k1), .k2(k2),
    .res_valid(rv_a), .res_cost(rc_a), .nreq(nreq_a), .ndone(ndone_a), .slog(slog_a), .first_bad(fb_a));

  tb_cand_src #(.CW(CW)) src_b (.clk(clk), .clr(clr), .eval_req(req_b), .cx(cx_b), .cy(cy_b),
    .step(st_b), .done(done_b), .tx(tx), .ty(ty), .base(base), .wx(wx), .wy(wy), .k1(k1), .k2(k2),
    .res_valid(rv_b), .res_cost(rc_b), .nreq(nreq_b), .ndone(ndone_b), .slog(slog_b), .first_bad(fb_b));

  function automatic int costf(input int x, input int y);
    int ax, ay;
    ax = (x > tx) ? x - tx : tx - x;
    ay = (y > ty) ? y - ty : ty - y;
    return base + wx * ax + wy * ay + (((x + 40) * k1 + (y + 40) * k2) % 8);
  endfunction

  task automatic ref_search(input int lo, input int hi, output int ex, output int ey,
                            output int el, output int ns, output logic [23:0] sl);
    int st, bi, bc, bx, by, c, x, y, j;
    el = (costf(0, 0) < int'(thresh)) ? 0 : 1;
    st = el ? 4 : 1;
    ex = 0; ey = 0; ns = 0; sl = '0;
    for (int k = 0; k < 3; k++) begin
      sl[(k+1)*3 +: 3] = 3'(st);
      bi = 0; bc = costf(ex, ey); bx = ex; by = ey;
      for (int i = 1; i < 9; i++) begin
        j = (i <= 4) ? i - 1 : i;
        x = ex + (j % 3 - 1) * st;
        y = ey + (j / 3 - 1) * st;
        c = (x < lo || x > hi || y < lo || y > hi) ? 65535 : costf(x, y);
        if (c < bc) begin bc = c; bi = i; bx = x; by = y; end
      end
      ex = bx; ey = by; ns = k + 1;
      if (!el && bi == 0) break;
      if (el) st = st / 2;
    end
  endtask

  task automatic chk(input bit ok, input string rq, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", rq, what, act, exp);
    end
  endtask

  task automatic check_one(input string nm, input int lo, input int hi, input int mvx, input int mvy,
                           input bit md, input int nr, input int nd, input logic [23:0] sl, input bit fb);
    int ex, ey, el, ns;
    logic [23:0] esl;
    ref_search(lo, hi, ex, ey, el, ns, esl);
    chk(mvx == ex && mvy == ey, "R5", {nm, " mv x*100+y"}, mvx * 100 + mvy, ex * 100 + ey);
    chk(int'(md) == el, "R2", {nm, " mode"}, int'(md), el);
    if (el) chk(nr == 4, "R4", {nm, " request count"}, nr, 4);
    else    chk(nr == ns + 1, "R3", {nm, " request count"}, nr, ns + 1);
    chk(sl == esl, el ? "R4" : "R3", {nm, " step log"}, int'(sl), int'(esl));
    chk(!fb, "R1", {nm, " origin request"}, int'(fb), 0);
    chk(nd == 1, "R8", {nm, " done pulses"}, nd, 1);
    chk(mvx >= lo && mvx <= hi && mvy >= lo && mvy <= hi, "R7", {nm, " mv range"}, mvx * 100 + mvy, ex * 100 + ey);
  endtask

  task automatic run(input int th, input int t_x, input int t_y, input int b, input int w_x,
                     input int w_y, input int q1, input int q2, input bit extra_start);
    int n;
    @(negedge clk);
    thresh = CW'(th); tx = t_x; ty = t_y; base = b; wx = w_x; wy = w_y; k1 = q1; k2 = q2;
    clr = 1;
    @(negedge clk);
    clr = 0; start = 1;
    @(negedge clk);
    start = 0;
    if (extra_start) begin
      @(negedge clk);
      @(negedge clk);
      chk(busy_a && busy_b, "R9", "busy before extra start", int'(busy_a), 1);
      start = 1;
      @(negedge clk);
      start = 0;
    end
    n = 0;
    while ((ndone_a == 0 || ndone_b == 0) && n < 300) begin
      @(negedge clk);
      n++;
    end
    chk(n < 300, "R8", "search completion", n, 0);
    repeat (8) @(negedge clk);
    chk(!busy_a && !busy_b, "R9", "idle after search", int'(busy_a) + int'(busy_b), 0);
    check_one("wide", -15, 16, int'(mvx_a), int'(mvy_a), mode_a, nreq_a, ndone_a, slog_a, fb_a);
    check_one("narrow", NLO, NHI, int'(mvx_b), int'(mvy_b), mode_b, nreq_b, ndone_b, slog_b, fb_b);
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd5813));
    repeat (3) @(negedge clk);
    // R11 reset state
    chk(!busy_a && !done_a && !req_a, "R11", "reset outputs", int'(busy_a) + int'(done_a) + int'(req_a), 0);
    rst_n = 1;
    @(negedge clk);
    chk(!busy_a && !req_a, "R11", "idle after reset", int'(busy_a) + int'(req_a), 0);
    // R2 R3: target at origin, small mode, one step
    run(60000, 0, 0, 100, 3, 3, 0, 0, 0);
    // R2 boundary: threshold equal to origin cost gives large mode
    run(100, 0, 0, 100, 3, 3, 0, 0, 0);
    run(101, 0, 0, 100, 3, 3, 0, 0, 0);
    // R6 flat surface: ties keep center in large mode
    run(0, 0, 0, 50, 0, 0, 0, 0, 0);
    // R4 R7 far target: narrow instance clipped by range mask
    run(0, 7, -7, 10, 5, 5, 0, 0, 0);
    run(0, 14, 14, 10, 9, 9, 0, 0, 0);
    // R3 small mode walking three unit steps
    run(60000, 3, 2, 10, 4, 4, 0, 0, 0);
    // R6 partial tie along x
    run(0, 2, 0, 20, 0, 4, 0, 0, 0);
    // R9 start pulse during a search
    run(0, 5, 3, 10, 3, 2, 1, 3, 1);
    run(60000, -2, 1, 10, 2, 2, 0, 0, 1);
    for (int r = 0; r < 60; r++) begin
      int t_x, t_y, b, w_x, w_y;
      t_x = int'($urandom % 25) - 12;
      t_y = int'($urandom % 25) - 12;
      b   = int'($urandom % 200);
      w_x = int'($urandom % 12);
      w_y = int'($urandom % 12);
      run(b + int'($urandom % 120), t_x, t_y, b, w_x, w_y, int'($urandom % 8), int'($urandom % 8), r % 7 == 0);
    end
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule